// File: doc/BRIEF.md
# Data-Processing ALU with Opcode Decode

This block is the integer execute stage for sixteen data-processing operations chosen by a 4-bit opcode. It takes a first operand and a second operand. The second operand has already been through the shifter. It also takes the current condition flags, the carry produced by the shifter, and a request to update the flags. It returns the result, a register write-enable and the next N, Z, C and V flags.

The operation groups are bitwise logic, moves, add and add-with-carry, subtract, and reverse subtract. Both subtract forms have carry-chained variants. In these variants a set carry means that no borrow is owed. Four compare and test opcodes work out a value only to set the flags, and they never request a register write.

All outputs are registered, so each output appears one clock after its inputs are presented. A synchronous active-high reset clears the result, the write-enable and the flags.

Top module: `dp_alu`

## Requirements
- R1: The logical opcodes produce: 0 A AND B, 1 A XOR B, 12 A OR B, 13 B, 14 A AND NOT B, 15 NOT B. All are 32 bits wide.
- R2: Opcode 4 produces A+B. Opcode 5 produces A+B+C, where C is flags_i bit 1.
- R3: Opcode 2 produces A-B and opcode 3 produces B-A. Opcode 6 produces A-B-NOT(C) and opcode 7 produces B-A-NOT(C). All results are taken modulo 2^32.
- R4: Opcodes 8 to 11 (test, test-equivalence, compare, compare-negative) never assert wr_en_o. Their flags update even when set_flags_i is low. Their result values are 8: A AND B, 9: A XOR B, 10: A-B, 11: A+B.
- R5: Every opcode outside 8 to 11 asserts wr_en_o.
- R6: When the flags update, N (flags_o bit 3) equals result bit 31, and Z (flags_o bit 2) is 1 exactly when all result bits are zero.
- R7: When the flags update, C (flags_o bit 1) is the carry out for the add class (opcodes 4, 5, 11). For the subtract classes (2, 6, 10 and 3, 7) it is the inverted borrow of the operand order actually used.
- R8: When the flags update, V (flags_o bit 0) is the signed overflow of the performed add or subtract, with the carry-in term included.
- R9: For the logical class (0, 1, 8, 9, 12-15), an update loads C from shift_carry_i and keeps V equal to flags_i bit 0.
- R10: When set_flags_i is low and the opcode is outside 8 to 11, flags_o equals flags_i.
- R11: Outputs appear one clock after the inputs. Reset clears result_o, wr_en_o and flags_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation select |
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Second operand B, already shifted |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shift_carry_i | input | 1 | Carry out of the shifter |
| set_flags_i | input | 1 | Request to update the flags |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered register write-enable |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Assertions check four rules on every cycle. Compare and test opcodes never write a register. The flags hold their value when no update is requested. Updated N and Z always agree with the registered result. A logical-class update always keeps the previous V. The bench's directed scenarios are the only place that shows the arithmetic values and the carry and overflow decisions. These include the inverted-borrow convention for carry-chained subtracts, reverse-subtract operand order, and overflow caused only by the carry-in. The bench checks all of these against a wide-integer reference model, over every opcode.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ADD   = 2'd1,
    CLS_SUB   = 2'd2,
    CLS_RSB   = 2'd3
  } alu_cls_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
  localparam int FLG_W = 4;
endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_cls_e   cls_o,
  output logic       flag_only_o,
  output logic       use_carry_o
);
  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_ADD, OP_ADC, OP_CMN: cls_o = CLS_ADD;
      OP_SUB, OP_SBC, OP_CMP: cls_o = CLS_SUB;
      OP_RSB, OP_RSC:         cls_o = CLS_RSB;
      default:                cls_o = CLS_LOGIC;
    endcase
  end

  assign flag_only_o = (op_i[3:2] == 2'b10);
  assign use_carry_o = (alu_op_e'(op_i) == OP_ADC) || (alu_op_e'(op_i) == OP_SBC) ||
                       (alu_op_e'(op_i) == OP_RSC);
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  alu_cls_e         cls_i,
  input  logic             use_carry_i,
  input  logic             carry_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y, logic_res;
  logic             cin;
  logic [WIDTH:0]   sum;

  always_comb begin
    x   = a_i;
    y   = b_i;
    cin = 1'b0;
    unique case (cls_i)
      CLS_ADD: begin
        x = a_i; y = b_i;  cin = use_carry_i ? carry_i : 1'b0;
      end
      CLS_SUB: begin
        x = a_i; y = ~b_i; cin = use_carry_i ? carry_i : 1'b1;
      end
      CLS_RSB: begin
        x = b_i; y = ~a_i; cin = use_carry_i ? carry_i : 1'b1;
      end
      default: ;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: logic_res = a_i & b_i;
      OP_XOR, OP_TEQ: logic_res = a_i ^ b_i;
      OP_ORR:         logic_res = a_i | b_i;
      OP_MOV:         logic_res = b_i;
      OP_BIC:         logic_res = a_i & ~b_i;
      default:        logic_res = ~b_i;
    endcase
  end

  assign res_o  = (cls_i == CLS_LOGIC) ? logic_res : sum[WIDTH-1:0];
  assign cout_o = sum[WIDTH];
  assign ovf_o  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_cls_e         cls_i,
  input  logic             update_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic             shift_carry_i,
  input  logic [FLG_W-1:0] flags_i,
  output logic [FLG_W-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    if (update_i) begin
      flags_o[FLG_N] = res_i[WIDTH-1];
      flags_o[FLG_Z] = (res_i == '0);
      if (cls_i == CLS_LOGIC) begin
        flags_o[FLG_C] = shift_carry_i;
      end else begin
        flags_o[FLG_C] = cout_i;
        flags_o[FLG_V] = ovf_i;
      end
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       flags_i,
  input  logic             shift_carry_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  alu_cls_e         cls;
  logic             flag_only, use_carry, cout, ovf, update;
  logic [WIDTH-1:0] res_d;
  logic [FLG_W-1:0] flags_d;

  dp_alu_decode u_dec (
    .op_i(op_i), .cls_o(cls), .flag_only_o(flag_only), .use_carry_o(use_carry)
  );

  dp_alu_core #(.WIDTH(WIDTH)) u_core (
    .op_i(op_i), .cls_i(cls), .use_carry_i(use_carry), .carry_i(flags_i[FLG_C]),
    .a_i(opa_i), .b_i(opb_i), .res_o(res_d), .cout_o(cout), .ovf_o(ovf)
  );

  assign update = set_flags_i || flag_only;

  dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .cls_i(cls), .update_i(update), .res_i(res_d), .cout_i(cout), .ovf_i(ovf),
    .shift_carry_i(shift_carry_i), .flags_i(flags_i), .flags_o(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= res_d;
      wr_en_o  <= !flag_only;
      flags_o  <= flags_d;
    end
  end

  // R4: compare/test never writes a register
  assert_no_write_on_compare_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i[3:2] == 2'b10) |=> !wr_en_o);

  // R10: flags hold without an update request
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!set_flags_i && op_i[3:2] != 2'b10) |=> (flags_o == $past(flags_i)));

  // R6: updated N and Z track the registered result
  assert_nz_match_R6: assert property (@(posedge clk) disable iff (rst)
    update |=> (flags_o[FLG_Z] == (result_o == '0)) && (flags_o[FLG_N] == result_o[WIDTH-1]));

  // R9: logical-class update keeps V
  assert_logic_keeps_v_R9: assert property (@(posedge clk) disable iff (rst)
    (update && cls == CLS_LOGIC) |=> (flags_o[FLG_V] == $past(flags_i[FLG_V])));
endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  fl = '0;
  logic        shc = 1'b0, sf = 1'b0;
  logic [31:0] res;
  logic        wr;
  logic [3:0]  flo;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rst(rst), .op_i(op), .opa_i(a), .opb_i(b), .flags_i(fl),
    .shift_carry_i(shc), .set_flags_i(sf), .result_o(res), .wr_en_o(wr), .flags_o(flo)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model
  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] f, input logic sc, input logic s,
                       output logic [31:0] er, output logic ew, output logic [3:0] ef);
    longint ux, uy, sx, sy, u, sg;
    logic c, nb, arith, cc, vv;
    ux = longint'({32'b0, x}); uy = longint'({32'b0, y});
    sx = longint'(signed'(x)); sy = longint'(signed'(y));
    c = f[1]; nb = !c; arith = 1; u = 0; sg = 0; er = '0;
    case (o)
      4'h0, 4'h8: begin er = x & y; arith = 0; end
      4'h1, 4'h9: begin er = x ^ y; arith = 0; end
      4'hC: begin er = x | y; arith = 0; end
      4'hD: begin er = y; arith = 0; end
      4'hE: begin er = x & ~y; arith = 0; end
      4'hF: begin er = ~y; arith = 0; end
      4'h4, 4'hB: begin u = ux + uy; sg = sx + sy; end
      4'h5: begin u = ux + uy + longint'(c); sg = sx + sy + longint'(c); end
      4'h2, 4'hA: begin u = ux - uy; sg = sx - sy; end
      4'h6: begin u = ux - uy - longint'(nb); sg = sx - sy - longint'(nb); end
      4'h3: begin u = uy - ux; sg = sy - sx; end
      default: begin u = uy - ux - longint'(nb); sg = sy - sx - longint'(nb); end
    endcase
    if (arith) er = u[31:0];
    if (o == 4'h4 || o == 4'h5 || o == 4'hB) cc = (u > 64'sh0FFFFFFFF);
    else cc = (u >= 0);
    vv = (sg > 64'sh7FFFFFFF) || (sg < -64'sh80000000);
    ew = !(o >= 4'h8 && o <= 4'hB);
    ef = f;
    if (s || !ew) begin
      ef[3] = er[31];
      ef[2] = (er == 0);
      ef[1] = arith ? cc : sc;
      ef[0] = arith ? vv : f[0];
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    if (o >= 4'h8 && o <= 4'hB) return "R4";
    if (o == 4'h4 || o == 4'h5) return "R2";
    if (o >= 4'h2 && o <= 4'h7) return "R3";
    return "R1";
  endfunction

  task automatic apply(input string tag, input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [3:0] f, input logic sc, input logic s);
    logic [31:0] er; logic ew; logic [3:0] ef;
    model(o, x, y, f, sc, s, er, ew, ef);
    @(negedge clk);
    op = o; a = x; b = y; fl = f; shc = sc; sf = s;
    @(negedge clk);
    chk({tag, " result"}, res, er);
    chk({tag, " wr_en"}, {31'b0, wr}, {31'b0, ew});
    chk({tag, " flags"}, {28'b0, flo}, {28'b0, ef});
  endtask

  task automatic t_reset;
    chk("R11 reset result", res, 32'h0);
    chk("R11 reset wr_en", {31'b0, wr}, 32'h0);
    chk("R11 reset flags", {28'b0, flo}, 32'h0);
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 16; o++) begin
      apply(tag_of(4'(o)), 4'(o), 32'hF0F0_1234, 32'h0FF0_8765, 4'b0000, 1'b1, 1'b1);
      apply(tag_of(4'(o)), 4'(o), 32'h8000_0001, 32'hFFFF_FFFF, 4'b0011, 1'b0, 1'b1);
      apply("R5", 4'(o), 32'h0000_0005, 32'h0000_0003, 4'b0010, 1'b0, 1'b0);
    end
  endtask

  task automatic t_borrow;
    apply("R3 sbc no-borrow", 4'h6, 32'd5, 32'd3, 4'b0010, 1'b0, 1'b1);
    chk("R3 sbc c=1 value", res, 32'd2);
    apply("R3 sbc borrow", 4'h6, 32'd5, 32'd3, 4'b0000, 1'b0, 1'b1);
    chk("R3 sbc c=0 value", res, 32'd1);
    apply("R7 sub borrow", 4'h2, 32'd0, 32'd1, 4'b0000, 1'b0, 1'b1);
    chk("R7 carry clear", {31'b0, flo[1]}, 32'd0);
    apply("R3 rsb order", 4'h3, 32'd3, 32'd10, 4'b0000, 1'b0, 1'b1);
    chk("R3 rsb value", res, 32'd7);
    apply("R3 rsc", 4'h7, 32'd10, 32'd3, 4'b0000, 1'b0, 1'b1);
    apply("R7 equal cmp", 4'hA, 32'h1234, 32'h1234, 4'b0000, 1'b0, 1'b0);
    chk("R6 zero flag", {28'b0, flo}, 32'b0110);
  endtask

  task automatic t_overflow;
    apply("R8 add ovf", 4'h4, 32'h7FFF_FFFF, 32'd1, 4'b0000, 1'b0, 1'b1);
    chk("R8 n,v set", {28'b0, flo}, 32'b1001);
    apply("R8 adc carry-in ovf", 4'h5, 32'h7FFF_FFFF, 32'd0, 4'b0010, 1'b0, 1'b1);
    apply("R7 add carry", 4'h4, 32'hFFFF_FFFF, 32'd1, 4'b0000, 1'b0, 1'b1);
    chk("R7 c,z set", {28'b0, flo}, 32'b0110);
    apply("R8 sub ovf", 4'h2, 32'h8000_0000, 32'd1, 4'b0000, 1'b0, 1'b1);
    apply("R8 sbc carry ovf", 4'h6, 32'h8000_0000, 32'd0, 4'b0000, 1'b0, 1'b1);
    apply("R8 cmn", 4'hB, 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b0, 1'b0);
  endtask

  task automatic t_logic_flags;
    apply("R9 logic c from shifter", 4'hD, 32'h0, 32'h0, 4'b0001, 1'b1, 1'b1);
    chk("R9 v kept c loaded", {28'b0, flo}, 32'b0111);
    apply("R9 tst", 4'h8, 32'hFFFF_0000, 32'h8000_0000, 4'b0010, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    apply("R10 hold", 4'h2, 32'd0, 32'd1, 4'b1011, 1'b0, 1'b0);
    chk("R10 flags unchanged", {28'b0, flo}, 32'b1011);
    apply("R10 hold logic", 4'hF, 32'd0, 32'd0, 4'b0100, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_sweep();
    t_borrow();
    t_overflow();
    t_logic_flags();
    t_hold();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule